// File: doc/BRIEF.md
# Sticky Level-Capture Interrupt Bank

This block watches a group of asynchronous input lines and records any line that reaches its active level in a sticky status bit. It is meant for short supervisory pulses, such as power-fail or brown-out strobes, that can vanish before software responds. The bit stays set until software writes a one to the channel's clear bit, so the event is never lost.

Each input first passes through a multi-stage synchroniser into the register clock. It is then compared with a per-channel active-level select and latched. A 32-bit register port reads and writes the enable, active-level, clear and mode words, and reads the raw and masked status words. The masked status is the raw status ANDed with the enable word. One interrupt output is the OR of the masked status. Only level capture is supported, so the mode word is fixed at zero.

Top module: `level_latch_bank`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_out` is 0. The active-level word resets to 0, which selects active-high capture on every channel.
- R2: The enable word is at offset 0x00 and is read/write on bits 7:0. Bits 31:8 of every read are 0, whatever was written.
- R3: When a channel's active-level bit is 0, a high input sets that channel's raw status bit (offset 0x04, bit n = channel n). The bit first reads 1 after the third rising clock edge following the input change.
- R4: When a channel's active-level bit (offset 0x10) is 1, a low input sets that channel's raw status bit.
- R5: A set raw status bit stays set after the input returns to its inactive level, until that channel is cleared.
- R6: A write to offset 0x0C clears the raw status bit of every channel whose data bit is 1 and leaves the other channels unchanged. If a channel's input is still at its active level, its bit stays set, because capture wins over clear.
- R7: The masked status at offset 0x08 equals raw status AND enable, and `irq_out` is 1 exactly when the masked status is nonzero.
- R8: Reads at offset 0x0C, at the mode offset 0x14, and at any offset other than 0x00, 0x04, 0x08, 0x10 and 0x14 return 0.
- R9: Writes to the raw status, masked status and mode offsets change no register and no status bit.
- R10: Capture does not depend on enable. A bit latched while its channel is disabled raises `irq_out` once the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and capture clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, applied at the rising edge |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 8 | Asynchronous event inputs, one per channel |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An input change reaches raw status three edges later: two synchroniser stages and then the latch. The bench therefore waits at least four cycles after each stimulus before reading, and one directed test samples the cycle before and the cycle of the transition to pin the latency exactly. A register write takes effect at the edge that samples it, and reads are combinational. So clears, enables and active-level changes are read back at the next falling edge, and `irq_out` is sampled at the same falling edge as the masked status it follows.

// File: rtl/llb_pkg.sv
package llb_pkg;

    localparam int LLB_DATA_W = 32;
    localparam int LLB_ADDR_W = 8;

    typedef enum logic [LLB_ADDR_W-1:0] {
        OFF_ENABLE = 8'h00,
        OFF_RAW    = 8'h04,
        OFF_MASKED = 8'h08,
        OFF_CLEAR  = 8'h0C,
        OFF_LEVEL  = 8'h10,
        OFF_MODE   = 8'h14
    } reg_off_e;

    typedef enum logic [2:0] {
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_LEVEL,
        SEL_MODE,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [LLB_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_ENABLE: s = SEL_ENABLE;
            OFF_RAW:    s = SEL_RAW;
            OFF_MASKED: s = SEL_MASKED;
            OFF_CLEAR:  s = SEL_CLEAR;
            OFF_LEVEL:  s = SEL_LEVEL;
            OFF_MODE:   s = SEL_MODE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/llb_sync.sv
module llb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/llb_latch.sv
module llb_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] active_low,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status
);
    generate
        for (genvar c = 0; c < W; c++) begin : g_chan
            logic hit;
            logic drop;
            assign hit  = lvl[c] ^ active_low[c];
            assign drop = clr_stb & clr_bits[c];
            always_ff @(posedge clk) begin
                if (rst)       status[c] <= 1'b0;
                else if (hit)  status[c] <= 1'b1;
                else if (drop) status[c] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/llb_regs.sv
module llb_regs
    import llb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [LLB_ADDR_W-1:0] addr,
    input  logic [LLB_DATA_W-1:0] wdata,
    input  logic [W-1:0]          status,
    output logic [W-1:0]          enable,
    output logic [W-1:0]          active_low,
    output logic                  clr_stb,
    output logic [W-1:0]          clr_bits,
    output logic [W-1:0]          masked,
    output logic [LLB_DATA_W-1:0] rdata
);
    reg_sel_e sel;
    logic [W-1:0] wbits;

    assign sel   = decode_offset(addr);
    assign wbits = wdata[W-1:0];

    generate
        if (W < LLB_DATA_W) begin : g_hi
            logic wdata_unused_hi;
            assign wdata_unused_hi = ^wdata[LLB_DATA_W-1:W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            enable     <= '0;
            active_low <= '0;
        end else if (wr) begin
            if (sel == SEL_ENABLE) enable     <= wbits;
            if (sel == SEL_LEVEL)  active_low <= wbits;
        end
    end

    assign clr_stb  = wr && (sel == SEL_CLEAR);
    assign clr_bits = wbits;
    assign masked   = status & enable;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ENABLE: rdata[W-1:0] = enable;
            SEL_RAW:    rdata[W-1:0] = status;
            SEL_MASKED: rdata[W-1:0] = masked;
            SEL_LEVEL:  rdata[W-1:0] = active_low;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/level_latch_bank.sv
module level_latch_bank
    import llb_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [LLB_ADDR_W-1:0] reg_addr,
    input  logic [LLB_DATA_W-1:0] reg_wdata,
    output logic [LLB_DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0]     evt_in,
    output logic                  irq_out
);
    logic [NUM_CH-1:0] lvl_sync;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] cfg_en;
    logic [NUM_CH-1:0] cfg_low;
    logic              clr_stb;
    logic [NUM_CH-1:0] clr_bits;
    logic [NUM_CH-1:0] masked;

    llb_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_in(evt_in), .sync_out(lvl_sync)
    );

    llb_latch #(.W(NUM_CH)) latch_i (
        .clk(clk), .rst(rst), .lvl(lvl_sync), .active_low(cfg_low),
        .clr_stb(clr_stb), .clr_bits(clr_bits), .status(status_q)
    );

    llb_regs #(.W(NUM_CH)) regs_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .status(status_q), .enable(cfg_en), .active_low(cfg_low),
        .clr_stb(clr_stb), .clr_bits(clr_bits), .masked(masked),
        .rdata(reg_rdata)
    );

    assign irq_out = |masked;
endmodule

// File: rtl/llb_chk.sv
module llb_chk
    import llb_pkg::*;
#(
    parameter int W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr,
    input logic [LLB_ADDR_W-1:0] reg_addr,
    input logic [LLB_DATA_W-1:0] reg_wdata,
    input logic [LLB_DATA_W-1:0] reg_rdata,
    input logic                  irq_out,
    input logic [W-1:0]          status,
    input logic [W-1:0]          lvl,
    input logic [W-1:0]          low
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == OFF_CLEAR);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && !irq_out));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[LLB_DATA_W-1:W] == '0);

    // R3
    set_needs_level_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~($past(lvl) ^ $past(low))) == '0));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((status & $past(status)) == $past(status)));

    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((status & $past(reg_wdata[W-1:0]) & ~($past(lvl) ^ $past(low))) == '0));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (status != '0));
endmodule

bind level_latch_bank llb_chk #(.W(NUM_CH)) chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
    .status(status_q), .lvl(lvl_sync), .low(cfg_low)
);

// File: tb/level_latch_bank_tb.sv
module level_latch_bank_tb_top;
    localparam time CLK_PERIOD = 4ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_in = '0;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // fields: level[31:24] enable[23:16] input[15:8] expected raw[7:0]
    localparam logic [31:0] VECS [0:5] = '{
        32'h00_FF_01_01,
        32'h00_0F_A5_A5,
        32'hFF_FF_FE_01,
        32'hF0_3C_30_C0,
        32'h0F_FF_0F_00,
        32'hAA_81_55_FF
    };

    level_latch_bank dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, r); check("R1 enable", r, 0);
        rd(8'h04, r); check("R1 raw", r, 0);
        rd(8'h10, r); check("R1 level", r, 0);
        check("R1 irq", {31'b0, irq_out}, 0);

        // R2 upper bits read zero
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); check("R2 enable width", r, 32'h0000_00FF);
        wr(8'h00, 32'h0);

        // table walk: R3 R4 R5 R7
        for (int i = 0; i < 6; i++) begin
            logic [7:0] lv, en, inp, exp;
            {lv, en, inp, exp} = VECS[i];
            evt_in = lv;
            wr(8'h10, {24'b0, lv});
            wr(8'h00, {24'b0, en});
            idle(4);
            wr(8'h0C, 32'hFF);
            rd(8'h04, r); check("R3/R4 idle raw", r, 0);
            evt_in = inp;
            idle(4);
            rd(8'h04, r); check("R3/R4 raw", r, {24'b0, exp});
            rd(8'h08, r); check("R7 masked", r, {24'b0, exp & en});
            check("R7 irq", {31'b0, irq_out}, {31'b0, |(exp & en)});
            evt_in = lv;
            idle(4);
            rd(8'h04, r); check("R5 sticky", r, {24'b0, exp});
            wr(8'h0C, 32'hFF);
        end

        // R3 exact latency
        wr(8'h10, 0); wr(8'h00, 0); evt_in = 8'h00; idle(4); wr(8'h0C, 32'hFF);
        @(negedge clk); evt_in = 8'h08;
        @(negedge clk); @(negedge clk);
        rd(8'h04, r); check("R3 before third edge", r, 0);
        @(negedge clk);
        rd(8'h04, r); check("R3 third edge", r, 32'h08);

        // R6 partial clear and clear while active
        evt_in = 8'hA5; idle(4); evt_in = 8'h00; idle(4);
        rd(8'h04, r); check("R6 setup", r, 32'hAD);
        wr(8'h0C, 32'h05);
        rd(8'h04, r); check("R6 partial clear", r, 32'hA8);
        evt_in = 8'h80; idle(4);
        wr(8'h0C, 32'h80);
        rd(8'h04, r); check("R6 capture wins", r, 32'hA8);
        evt_in = 8'h00; idle(4);
        wr(8'h0C, 32'hFF);
        rd(8'h04, r); check("R6 full clear", r, 0);

        // R8 read-zero offsets
        wr(8'h00, 32'hFF); wr(8'h10, 32'h00);
        rd(8'h0C, r); check("R8 clear reads 0", r, 0);
        rd(8'h14, r); check("R8 mode reads 0", r, 0);
        rd(8'h18, r); check("R8 unmapped 18", r, 0);
        rd(8'h40, r); check("R8 unmapped 40", r, 0);
        rd(8'h01, r); check("R8 unaligned", r, 0);

        // R9 writes to read-only offsets
        wr(8'h04, 32'hFF); wr(8'h08, 32'hFF); wr(8'h14, 32'hFF);
        rd(8'h04, r); check("R9 raw untouched", r, 0);
        rd(8'h14, r); check("R9 mode untouched", r, 0);
        rd(8'h00, r); check("R9 enable untouched", r, 32'hFF);
        rd(8'h10, r); check("R9 level untouched", r, 0);
        check("R9 irq low", {31'b0, irq_out}, 0);

        // R10 capture while disabled
        wr(8'h00, 32'h00);
        evt_in = 8'h10; idle(4); evt_in = 8'h00; idle(4);
        check("R10 irq disabled", {31'b0, irq_out}, 0);
        rd(8'h04, r); check("R10 raw latched", r, 32'h10);
        wr(8'h00, 32'h10);
        check("R10 irq after enable", {31'b0, irq_out}, 1);

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd(8'h04, r); check("R1 raw after reset", r, 0);
        rd(8'h00, r); check("R1 enable after reset", r, 0);
        check("R1 irq after reset", {31'b0, irq_out}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule